// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is an 8-bit general-purpose I/O port. It has a small register interface with 16-bit words. For each pin, software sets a drive value, an output enable, a pull resistor (with its direction) and an edge interrupt (with its polarity and an enable). The block produces the pad-side control signals: drive value, output enable, pull enable and pull direction. It also produces one combined interrupt request line.

The pad input is resynchronized by two flops. A third flop holds the previous sample, and a comparison with it detects rising or falling edges. Each detected edge sets a sticky flag that software clears by writing 1. A separate per-pin mode input marks pins that belong to a peripheral. For those pins the block drives all of its pad controls low and records no edges.

The register words are selected by a 2-bit address:

| Address | Bits 15–8 | Bits 7–0 |
|---|---|---|
| 0 | output enable | drive value |
| 1 | pull direction (1 = pull-up) | pull enable |
| 2 | reserved, read as 0 | interrupt flags |
| 3 | edge select (1 = falling) | interrupt enable |

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0x0000 and every pad output and `irq` are 0.
- R2: Address 0 holds the output enable in bits 15–8 and the drive value in bits 7–0. For a pin in GPIO mode, `pad_oe` follows its enable bit and `pad_dout` follows its drive bit.
- R3: Address 1 holds the pull direction in bits 15–8 (1 = up, 0 = down) and the pull enable in bits 7–0. A GPIO pin has `pad_pull_en` high only when its pull enable is 1 and its output enable is 0. `pad_pull_up` is high only when the pin is pulled and its direction bit is 1.
- R4: With edge select 0 (address 3, bits 15–8), a 0-to-1 change on `pad_in` sets the pin's flag. The flag reads 1 after the third rising clock edge following the change, and still reads 0 after the second.
- R5: With edge select 1, a 1-to-0 change sets the flag. A change in the other direction does not set it.
- R6: Address 2 returns the flags in bits 7–0 and 0 in bits 15–8. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R7: When an edge sets a flag in the same cycle that a write-1 clears it, the flag ends up set.
- R8: `irq` is the OR over all pins of (flag AND interrupt enable), where the enable sits in address 3, bits 7–0. Flags are still recorded while the enable is 0.
- R9: For a pin with `periph_mode` set to 1, `pad_oe`, `pad_dout`, `pad_pull_en` and `pad_pull_up` are 0, and edges on its input set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| pad_in | input | 8 | Input level from the pads |
| periph_mode | input | 8 | 1 = pin is owned by a peripheral |
| pad_dout | output | 8 | Drive value to the pads |
| pad_oe | output | 8 | Output enable to the pads |
| pad_pull_en | output | 8 | Pull resistor enable |
| pad_pull_up | output | 8 | Pull direction, 1 = pull-up |
| irq | output | 1 | Combined interrupt request |

## Verification
The pad gating is tried with a table of output-enable, pull-enable, pull-direction and mode patterns. The patterns are chosen so that each gating term changes at least one expected bit: an enabled output that blocks the pull, pull direction masking, and peripheral pins that mask everything. Edge detection is tried with rising and falling transitions on pins that select opposite polarities. This separates correct polarity handling from plain change detection. It is also sampled one cycle before the expected latency, which exposes a missing or extra synchronizer stage. Directed cases then place a clear write on the exact cycle of a set, change the interrupt enable after a flag is already recorded, and send edges to a pin in peripheral mode.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DRIVE = 2'd0,
    REG_PULL  = 2'd1,
    REG_FLAG  = 2'd2,
    REG_IRQ   = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = 8,
  localparam int unsigned BW  = 2 * PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen,
  input  logic [1:0]      addr,
  input  logic [BW-1:0]   wdata,
  input  logic [PINS-1:0] flags,
  output logic [BW-1:0]   rdata,
  output logic [PINS-1:0] drv_q,
  output logic [PINS-1:0] oe_q,
  output logic [PINS-1:0] pen_q,
  output logic [PINS-1:0] pdir_q,
  output logic [PINS-1:0] esel_q,
  output logic [PINS-1:0] ie_q,
  output logic [PINS-1:0] clr
);
  logic         we_drive, we_pull, we_irq;
  logic [BW-1:0] drive_d, pull_d, irqc_d;

  always_comb begin
    we_drive = wen && (addr == REG_DRIVE);
    we_pull  = wen && (addr == REG_PULL);
    we_irq   = wen && (addr == REG_IRQ);
    drive_d  = we_drive ? wdata : {oe_q, drv_q};
    pull_d   = we_pull  ? wdata : {pdir_q, pen_q};
    irqc_d   = we_irq   ? wdata : {esel_q, ie_q};
    clr      = (wen && (addr == REG_FLAG)) ? wdata[PINS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {oe_q, drv_q}   <= '0;
      {pdir_q, pen_q} <= '0;
      {esel_q, ie_q}  <= '0;
    end else begin
      {oe_q, drv_q}   <= drive_d;
      {pdir_q, pen_q} <= pull_d;
      {esel_q, ie_q}  <= irqc_d;
    end
  end

  always_comb begin
    unique case (addr)
      REG_DRIVE: rdata = {oe_q, drv_q};
      REG_PULL:  rdata = {pdir_q, pen_q};
      REG_FLAG:  rdata = {{PINS{1'b0}}, flags};
      default:   rdata = {esel_q, ie_q};
    endcase
  end

  // R2: a write to the drive word lands in the register
  p_drive_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_drive |=> ({oe_q, drv_q} == $past(wdata)));
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] esel,
  output logic [PINS-1:0] det
);
  logic [PINS-1:0] s0_q, s1_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q   <= '0;
      s1_q   <= '0;
      prev_q <= '0;
    end else begin
      s0_q   <= pad_in;
      s1_q   <= s0_q;
      prev_q <= s1_q;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      if (esel[i]) det[i] = prev_q[i] & ~s1_q[i];
      else         det[i] = s1_q[i] & ~prev_q[i];
    end
  end

  // R4: an edge is reported only when the sampled level actually changed
  p_det_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((det & ~(s1_q ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] det,
  input  logic [PINS-1:0] periph,
  input  logic [PINS-1:0] clr,
  input  logic [PINS-1:0] ie,
  output logic [PINS-1:0] flag_q,
  output logic            irq
);
  logic [PINS-1:0] set, flag_d;

  always_comb begin
    set    = det & ~periph;
    flag_d = (flag_q & ~clr) | set;
    irq    = |(flag_q & ie);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  // R6: a write-1 without a coincident set leaves the flag clear
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr & ~set) |=> ((flag_q & $past(clr & ~set)) == '0));
  // R7: a set always lands, even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |set |=> ((flag_q & $past(set)) == $past(set)));
  // R6: with neither set nor clear a flag holds its value
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flag_q ^ $past(flag_q)) & ~$past(set | clr)) == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] drv,
  input  logic [PINS-1:0] oe,
  input  logic [PINS-1:0] pen,
  input  logic [PINS-1:0] pdir,
  input  logic [PINS-1:0] periph,
  output logic [PINS-1:0] pad_dout,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pull_en,
  output logic [PINS-1:0] pad_pull_up
);
  logic [PINS-1:0] own;

  always_comb begin
    own         = ~periph;
    pad_dout    = drv & own;
    pad_oe      = oe & own;
    pad_pull_en = pen & ~oe & own;
    pad_pull_up = pdir & pad_pull_en;
  end

  // R3: a driven pin is never pulled at the same time
  p_pull_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_en & pad_oe) == '0));
  // R9: a peripheral pin receives no control from this port
  p_periph_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe | pad_dout | pad_pull_en | pad_pull_up) & periph) == '0));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int unsigned PINS = 8,
  localparam int unsigned BW  = 2 * PINS
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            bus_wen,
  input  logic [1:0]      bus_addr,
  input  logic [BW-1:0]   bus_wdata,
  output logic [BW-1:0]   bus_rdata,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] periph_mode,
  output logic [PINS-1:0] pad_dout,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pull_en,
  output logic [PINS-1:0] pad_pull_up,
  output logic            irq
);
  logic [1:0]      rst_pipe_q;
  logic            rst_n;
  logic [PINS-1:0] drv, oe, pen, pdir, esel, ie, clr, det, flags;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  gpio_regs #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr),
    .wdata(bus_wdata), .flags(flags), .rdata(bus_rdata),
    .drv_q(drv), .oe_q(oe), .pen_q(pen), .pdir_q(pdir),
    .esel_q(esel), .ie_q(ie), .clr(clr)
  );

  gpio_edge_det #(.PINS(PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .esel(esel), .det(det)
  );

  gpio_irq_flags #(.PINS(PINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .det(det), .periph(periph_mode),
    .clr(clr), .ie(ie), .flag_q(flags), .irq(irq)
  );

  gpio_pad_ctrl #(.PINS(PINS)) u_pad (
    .clk(clk), .rst_n(rst_n), .drv(drv), .oe(oe), .pen(pen), .pdir(pdir),
    .periph(periph_mode), .pad_dout(pad_dout), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
  );

  // R8: the request is raised only by an enabled, recorded flag
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & ie) != '0));
endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {drive word, pull word, periph, exp oe, exp dout, exp pull_en, exp pull_up}
  localparam logic [71:0] VEC [NVEC] = '{
    {16'hFFA5, 16'hFFFF, 8'h00, 8'hFF, 8'hA5, 8'h00, 8'h00},
    {16'h00A5, 16'h0FFF, 8'h00, 8'h00, 8'hA5, 8'hFF, 8'h0F},
    {16'hF03C, 16'hAACC, 8'h00, 8'hF0, 8'h3C, 8'h0C, 8'h08},
    {16'hF03C, 16'hAACC, 8'h0F, 8'hF0, 8'h30, 8'h00, 8'h00},
    {16'h0FFF, 16'h55FF, 8'h3C, 8'h03, 8'hC3, 8'hC0, 8'h40}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        bus_wen;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  pad_in, periph_mode;
  logic [7:0]  pad_dout, pad_oe, pad_pull_en, pad_pull_up;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port dut (
    .clk(clk), .rst_ni(rst_ni), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .periph_mode(periph_mode), .pad_dout(pad_dout), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [15:0] r;
    rst_ni = 1'b0; bus_wen = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    pad_in = '0; periph_mode = '0;
    tick(3);
    rst_ni = 1'b1;
    tick(3);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      chk("R1 reg", r, 16'h0000);
    end
    chk("R1 pads", {pad_oe, pad_dout}, 16'h0000);
    chk("R1 pulls", {pad_pull_en, pad_pull_up}, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 R3 R9: pad gating table
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd0, VEC[v][71:56]);
      wr(2'd1, VEC[v][55:40]);
      periph_mode = VEC[v][39:32];
      #1;
      rd(2'd0, r);
      chk("R2 readback", r, VEC[v][71:56]);
      chk("R2 R9 oe/dout", {pad_oe, pad_dout}, VEC[v][31:16]);
      chk("R3 R9 pull", {pad_pull_en, pad_pull_up}, VEC[v][15:0]);
    end
    periph_mode = '0;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);

    // R4 R5: bit1 falling, others rising, interrupts off
    wr(2'd3, 16'h0200);
    pad_in = 8'h03;
    tick(2);
    rd(2'd2, r);
    chk("R4 latency not early", r, 16'h0000);
    tick(1);
    rd(2'd2, r);
    chk("R4 R5 rise sets bit0 only", r, 16'h0001);
    chk("R8 no irq when disabled", {15'd0, irq}, 16'h0000);
    pad_in = 8'h00;
    tick(3);
    rd(2'd2, r);
    chk("R5 fall sets bit1", r, 16'h0003);

    // R6: write-1-clear, write-0 ignored, reserved byte reads 0
    wr(2'd2, 16'hFF02);
    rd(2'd2, r);
    chk("R6 w1c bit1", r, 16'h0001);
    wr(2'd2, 16'h0000);
    rd(2'd2, r);
    chk("R6 w0 no effect", r, 16'h0001);
    wr(2'd2, 16'h0001);
    rd(2'd2, r);
    chk("R6 clear all", r, 16'h0000);

    // R8: flag recorded while disabled, then enable raises irq
    pad_in = 8'h04;
    tick(3);
    chk("R8 irq still low", {15'd0, irq}, 16'h0000);
    wr(2'd3, 16'h0204);
    chk("R8 irq after enable", {15'd0, irq}, 16'h0001);
    wr(2'd2, 16'h0004);
    chk("R8 irq after clear", {15'd0, irq}, 16'h0000);

    // R7: clear write lands on the same edge as the set
    pad_in = 8'h0C;
    tick(2);
    rd(2'd2, r);
    chk("R7 flag not yet set", r, 16'h0000);
    bus_wen = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0008;
    tick(1);
    bus_wen = 1'b0;
    rd(2'd2, r);
    chk("R7 set wins", r, 16'h0008);
    wr(2'd2, 16'h0008);

    // R9: peripheral pin records no edge
    periph_mode = 8'h10;
    wr(2'd3, 16'h0010);
    pad_in = 8'h1C;
    tick(4);
    rd(2'd2, r);
    chk("R9 no flag in periph mode", r, 16'h0000);
    chk("R9 no irq in periph mode", {15'd0, irq}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule